// File: doc/BRIEF.md
# RTC Match Interrupt Controller

This block is a free-running seconds counter for a real-time clock. It raises an event when the count reaches a value that software has programmed. A 32-bit counter advances by one on each single-cycle tick strobe from an external prescaler. Software can preset the counter and read it back. A 32-bit compare register holds the target time.

When the counter enters equality with the compare register, a sticky raw status flag is set. An enable bit gates that flag onto the interrupt output and onto a separate masked status register. Software can therefore use the event in two ways:
- poll the raw flag with the interrupt disabled, or
- take the interrupt and read the masked flag in its handler.

A write-one clear register drops the flag. The block stays armed for the next equality.

Access is through a simple single-cycle register bus. A write takes effect at the clock edge on which `bus_sel` and `bus_write` are high. Read data is combinational while `bus_sel` is high and `bus_write` is low. At all other times `bus_rdata` is zero.

Top module: `rtc_match_ctrl`

## Requirements
- R1: After reset the following are all zero: the counter, the compare value, the enable bit, the raw flag and `irq`. The reset-time equality (count 0, compare 0) does not set the raw flag.
- R2: Each cycle with `tick` high increments the counter by one, wrapping from 0xFFFFFFFF to 0. The counter reads at offset 0x00.
- R3: A write to offset 0x08 presets the counter to the write data. If it falls in the same cycle as `tick`, the preset wins. Offset 0x08 reads as zero.
- R4: Offset 0x04 holds the 32-bit compare value, readable and writable.
- R5: Raw flag, read as bit 0 of offset 0x14:
  - It sets on the clock edge after the one on which the counter first becomes equal to the compare value, whatever the enable bit.
  - It stays set until cleared.
- R6: Enable bit, at bit 0 of offset 0x10:
  - A write stores bit 0 of the write data.
  - A read returns the stored bit in bit 0, with bits 31..1 reading as zero.
- R7: The masked flag is bit 0 of offset 0x18 and equals raw AND enable. `irq` equals the masked flag. Clearing the enable bit drops `irq` while the raw flag stays readable.
- R8: Clear register at offset 0x1C:
  - Writing a value with bit 0 set clears the raw and masked flags.
  - Writing bit 0 as 0 has no effect.
  - After a clear, the next entry into equality sets the flag again.
- R9: If a new entry into equality and a clear write fall in the same cycle, the raw flag ends set.
- R10: Writing the compare value does not clear a set raw flag. Writing a compare value equal to the current count is an entry into equality and sets the flag.
- R11: Reads of the write-only clear offset 0x1C and of unmapped offsets (for example 0x0C) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle count strobe |
| bus_sel | input | 1 | Register access select |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, zero when not reading |
| irq | output | 1 | Match interrupt, level |

## Verification
The critical collision is an entry into equality in the same cycle as a clear write. The bench sets up this collision with a set raw flag:
1. It presets the counter one below the compare value.
2. It pulses `tick`.
3. It drives the clear write in the very next cycle, which is the cycle in which the new equality is detected.

The raw flag must then read 1. A control run issues the same clear write with no equality pending, and the flag must read 0. A second collision also gets a directed check: a preset write in the same cycle as `tick`, where the preset value must be the one read back.

// File: rtl/rtc_match_pkg.sv
// Package: register offsets and internal write-strobe bundle for the
// RTC match interrupt controller. Offsets are byte addresses.
package rtc_match_pkg;
    localparam logic [7:0] OFS_COUNT    = 8'h00;
    localparam logic [7:0] OFS_MATCH    = 8'h04;
    localparam logic [7:0] OFS_LOAD     = 8'h08;
    localparam logic [7:0] OFS_ENABLE   = 8'h10;
    localparam logic [7:0] OFS_RAW      = 8'h14;
    localparam logic [7:0] OFS_MASKED   = 8'h18;
    localparam logic [7:0] OFS_CLEAR    = 8'h1C;

    // Width of the small status and enable registers as seen on the bus.
    localparam int STAT_W = 8;

    typedef struct packed {
        logic match_wr;
        logic load_wr;
        logic enable_wr;
        logic clear_wr;
    } rtc_wstrb_t;
endpackage

// File: rtl/rtc_reg_decode.sv
// Module: rtc_reg_decode
// Turns single-cycle bus writes into one-hot register strobes. It also
// builds the combinational read mux. Assumes that ADDR_W is at least 5
// and that bus_rdata must be zero whenever no read is in progress.
module rtc_reg_decode
    import rtc_match_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wdata_bit0,
    input  logic [DATA_W-1:0] count_val,
    input  logic [DATA_W-1:0] match_val,
    input  logic              enable_val,
    input  logic              raw_val,
    input  logic              masked_val,
    output rtc_wstrb_t        strb,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_MATCH  = ADDR_W'(OFS_MATCH);
    localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFS_LOAD);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);

    logic [STAT_W-1:0] enable_reg;
    logic [STAT_W-1:0] raw_reg;
    logic [STAT_W-1:0] masked_reg;

    // Purpose: widen the one-bit flags to their 8-bit register images.
    always_comb begin
        enable_reg = STAT_W'(enable_val);
        raw_reg    = STAT_W'(raw_val);
        masked_reg = STAT_W'(masked_val);
    end

    // Purpose: decode the write strobes for the addressed register.
    always_comb begin
        strb = '0;
        if (bus_sel && bus_write) begin
            case (bus_addr)
                A_MATCH:  strb.match_wr  = 1'b1;
                A_LOAD:   strb.load_wr   = 1'b1;
                A_ENABLE: strb.enable_wr = 1'b1;
                A_CLEAR:  strb.clear_wr  = wdata_bit0;
                default:  strb = '0;
            endcase
        end
    end

    // Purpose: select read data; write-only and unmapped offsets give zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_write) begin
            case (bus_addr)
                A_COUNT:  bus_rdata = count_val;
                A_MATCH:  bus_rdata = match_val;
                A_ENABLE: bus_rdata = DATA_W'(enable_reg);
                A_RAW:    bus_rdata = DATA_W'(raw_reg);
                A_MASKED: bus_rdata = DATA_W'(masked_reg);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_tick_counter.sv
// Module: rtc_tick_counter
// The seconds counter. It increments on each tick strobe and wraps at
// its width. A software preset takes priority over a tick in the same
// cycle. Assumes that tick is a clean, synchronous, one-cycle strobe.
module rtc_tick_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Purpose: hold, preset or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_wr) begin
            count_q <= load_val;
        end else if (tick) begin
            count_q <= count_q + ONE;
        end
    end
endmodule

// File: rtl/rtc_match_status.sv
// Module: rtc_match_status
// This module holds three things:
// - the compare register and the equality detector;
// - the sticky raw flag;
// - the interrupt enable bit.
// The flag sets on a 0->1 change of equality, so a count that sits on
// the compare value raises only one event. The flag resets to "equal"
// history, so that the equality at reset (both zero) is not an event.
module rtc_match_status #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_q,
    input  logic             match_wr,
    input  logic [CNT_W-1:0] match_wval,
    input  logic             enable_wr,
    input  logic             enable_wval,
    input  logic             clear_wr,
    output logic [CNT_W-1:0] match_q,
    output logic             enable_q,
    output logic             raw_q,
    output logic             match_evt
);
    logic equal_now;
    logic equal_q;

    // Purpose: detect the entry into equality against last cycle's state.
    always_comb begin
        equal_now = (count_q == match_q);
        match_evt = equal_now && !equal_q;
    end

    // Purpose: software-written compare value and enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q  <= '0;
            enable_q <= 1'b0;
        end else begin
            if (match_wr)  match_q  <= match_wval;
            if (enable_wr) enable_q <= enable_wval;
        end
    end

    // Purpose: equality history for the edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            equal_q <= 1'b1;
        end else begin
            equal_q <= equal_now;
        end
    end

    // Purpose: sticky raw flag; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (match_evt) begin
            raw_q <= 1'b1;
        end else if (clear_wr) begin
            raw_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_match_ctrl.sv
// Module: rtc_match_ctrl (top)
// Connects the following parts:
// - the register decoder;
// - the tick counter;
// - the match and status logic.
// irq is the raw flag gated by the enable bit and leaves the block as
// a level. Assumes a single clock domain and a synchronous tick strobe.
module rtc_match_ctrl
    import rtc_match_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    rtc_wstrb_t        strb;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] match_q;
    logic              enable_q;
    logic              raw_q;
    logic              match_evt;
    logic              masked;

    // Purpose: masked flag, which is shared by the status read and irq.
    always_comb begin
        masked = raw_q && enable_q;
        irq    = masked;
    end

    rtc_reg_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .bus_sel    (bus_sel),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .wdata_bit0 (bus_wdata[0]),
        .count_val  (count_q),
        .match_val  (match_q),
        .enable_val (enable_q),
        .raw_val    (raw_q),
        .masked_val (masked),
        .strb       (strb),
        .bus_rdata  (bus_rdata)
    );

    rtc_tick_counter #(
        .CNT_W (DATA_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load_wr  (strb.load_wr),
        .load_val (bus_wdata),
        .count_q  (count_q)
    );

    rtc_match_status #(
        .CNT_W (DATA_W)
    ) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_q     (count_q),
        .match_wr    (strb.match_wr),
        .match_wval  (bus_wdata),
        .enable_wr   (strb.enable_wr),
        .enable_wval (bus_wdata[0]),
        .clear_wr    (strb.clear_wr),
        .match_q     (match_q),
        .enable_q    (enable_q),
        .raw_q       (raw_q),
        .match_evt   (match_evt)
    );
endmodule

// File: rtl/rtc_match_chk.sv
// Module: rtc_match_chk
// Property checker for rtc_match_ctrl, attached by bind. It decodes the
// bus writes on its own and relates them to the counter, the raw flag
// and irq over time.
module rtc_match_chk
    import rtc_match_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_sel,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [DATA_W-1:0] cnt,
    input logic              raw,
    input logic              evt
);
    logic load_w;
    logic clr_w;
    logic en_w;

    // Purpose: independent decode of the writes that matter to the checks.
    always_comb begin
        load_w = bus_sel && bus_write && (bus_addr == ADDR_W'(OFS_LOAD));
        en_w   = bus_sel && bus_write && (bus_addr == ADDR_W'(OFS_ENABLE));
        clr_w  = bus_sel && bus_write && (bus_addr == ADDR_W'(OFS_CLEAR)) && bus_wdata[0];
    end

    AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_w) |=> (cnt == $past(cnt) + DATA_W'(1))); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_w && (cnt == '1)) |=> (cnt == '0)); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |=> (cnt == $past(bus_wdata))); // R3
    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr_w) |=> raw); // R5
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && !evt) |=> !raw); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> raw); // R9
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(evt) || $past(en_w))); // R7
endmodule

bind rtc_match_ctrl rtc_match_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_sel   (bus_sel),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .cnt       (count_q),
    .raw       (raw_q),
    .evt       (match_evt)
);

// File: tb/rtc_match_ctrl_tb.sv
// Bench for rtc_match_ctrl. It walks a vector table and then runs
// directed tests for reset, coincidences and corner cases.
module rtc_match_ctrl_tb;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              sel = 1'b0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    rtc_match_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(sel), .bus_write(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    // Vector table: op 0 = write, 1 = read and compare, 2 = tick pulse.
    localparam int NV = 29;
    localparam logic [1:0] V_OP [NV] = '{
        2'd1, 2'd1, 2'd0, 2'd1, 2'd2, 2'd1, 2'd2, 2'd2, 2'd1, 2'd1,
        2'd0, 2'd1, 2'd1, 2'd2, 2'd1, 2'd0, 2'd1, 2'd0, 2'd1, 2'd1,
        2'd0, 2'd1, 2'd2, 2'd1, 2'd1, 2'd1, 2'd1, 2'd0, 2'd1};
    localparam logic [7:0] V_ADDR [NV] = '{
        8'h00, 8'h14, 8'h04, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h14, 8'h18,
        8'h10, 8'h10, 8'h18, 8'h00, 8'h14, 8'h1C, 8'h14, 8'h1C, 8'h14, 8'h18,
        8'h08, 8'h00, 8'h00, 8'h00, 8'h08, 8'h1C, 8'h0C, 8'h04, 8'h04};
    localparam logic [31:0] V_DATA [NV] = '{
        32'h0, 32'h0, 32'h3, 32'h3, 32'h0, 32'h1, 32'h0, 32'h0, 32'h1, 32'h0,
        32'hFF, 32'h1, 32'h1, 32'h0, 32'h1, 32'h0, 32'h1, 32'h1, 32'h0, 32'h0,
        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'hA5A5_0F0F, 32'hA5A5_0F0F};
    // Requirement number that each table row exercises, used in messages.
    // Rows: R1 reset reads, R4 compare, R2 count, R5 raw, R7 masked,
    // R6 enable, R8 clear, R3 preset, R2 wrap, R11 zero reads.
    localparam int V_REQ [NV] = '{
        1, 1, 4, 4, 2, 2, 2, 2, 5, 7,
        6, 6, 7, 5, 5, 8, 8, 8, 8, 7,
        3, 3, 2, 2, 11, 11, 11, 4, 4};

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        d = rdata;
        sel = 1'b0;
    endtask

    task automatic tick_pulse();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        check(req, v, exp);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1_irq_reset", {31'd0, irq}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            case (V_OP[i])
                2'd0: bus_wr(V_ADDR[i], V_DATA[i]);
                2'd1: rd_check($sformatf("R%0d_table_row%0d", V_REQ[i], i), V_ADDR[i], V_DATA[i]);
                default: tick_pulse();
            endcase
        end
        // Table leaves: count 0, compare 0xA5A50F0F, enable 1, raw 0.

        // R7: irq follows the masked flag; disabling keeps raw visible.
        bus_wr(8'h04, 32'd5);
        bus_wr(8'h08, 32'd4);
        tick_pulse();
        @(negedge clk);
        check("R7_irq_on", {31'd0, irq}, 32'd1);
        bus_wr(8'h10, 32'd0);
        check("R7_irq_off", {31'd0, irq}, 32'd0);
        rd_check("R7_raw_kept", 8'h14, 32'd1);
        bus_wr(8'h10, 32'd1);

        // R10: a compare write leaves a set flag alone.
        bus_wr(8'h04, 32'd77);
        rd_check("R10_match_wr_keeps", 8'h14, 32'd1);

        // R8: clear, then re-arm on the next equality.
        bus_wr(8'h1C, 32'd1);
        rd_check("R8_cleared", 8'h14, 32'd0);
        bus_wr(8'h04, 32'd20);
        bus_wr(8'h08, 32'd19);
        tick_pulse();
        rd_check("R8_rearm", 8'h14, 32'd1);

        // R9: entry into equality and clear write in the same cycle.
        bus_wr(8'h08, 32'd19);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        sel = 1'b1; wr = 1'b1; addr = 8'h1C; wdata = 32'd1;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        rd_check("R9_set_wins", 8'h14, 32'd1);
        bus_wr(8'h1C, 32'd1);
        rd_check("R9_control_clear", 8'h14, 32'd0);

        // R10: writing a compare equal to the current count is an event.
        bus_wr(8'h04, 32'd21);
        bus_wr(8'h04, 32'd20);
        rd_check("R10_match_eq_count", 8'h14, 32'd1);
        bus_wr(8'h1C, 32'd1);

        // R3: a preset in the same cycle as a tick wins.
        @(negedge clk);
        tick = 1'b1; sel = 1'b1; wr = 1'b1; addr = 8'h08; wdata = 32'd100;
        @(negedge clk);
        tick = 1'b0; sel = 1'b0; wr = 1'b0;
        rd_check("R3_load_beats_tick", 8'h00, 32'd100);

        // R1: a reset in the middle of a run restores every register.
        bus_wr(8'h04, 32'd101);
        tick_pulse();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1_irq_after_reset", {31'd0, irq}, 32'd0);
        rd_check("R1_count_reset", 8'h00, 32'd0);
        rd_check("R1_match_reset", 8'h04, 32'd0);
        rd_check("R1_enable_reset", 8'h10, 32'd0);
        repeat (3) @(negedge clk);
        rd_check("R1_no_reset_event", 8'h14, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule